// File: doc/BRIEF.md
# Cascadable Dual Interval Timers

Two down-counting interval timers, A and B, share one small byte-wide register window. Each timer holds a counter, a reload latch of the same width and a control byte. While a timer runs, its counter steps down by one on every cycle where the clock-enable input is high. When a step is due with the counter already at zero, the counter reloads from its latch and the timer raises a one-cycle underflow pulse on its interrupt-source line.

Software sets the reload value byte by byte. Writing the most significant latch byte while the timer is stopped copies the whole latch into the counter. A control strobe can also force that copy at any time. Each timer can stop itself after its first underflow. Timer B can be set to step on timer A underflows instead of the clock enable, which joins the two into one 32-bit interval.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every readable location returns 0x00 and both underflow lines are low. Addresses are 0 (A low byte), 1 (A high byte), 2 (B low byte), 3 (B high byte), 4 (A control) and 5 (B control).
- R2: A write to a byte address (0 to 3) updates only the reload latch, and a read of it returns the live counter byte, so a running counter is not disturbed by latch writes.
- R3: Writing the high latch byte (address 1 or 3) while control bit 0 of that timer is clear loads the counter with the full new latch value.
- R4: With control bit 0 set, the counter drops by one on each cycle where tick_i is high. It holds when tick_i is low or bit 0 is clear.
- R5: When a step is due with the counter at zero, the counter reloads from the latch and that timer's underflow line (irq_o bit 0 for A, bit 1 for B) is high for that one cycle only, giving one pulse every latch+1 steps.
- R6: With control bit 3 set, an underflow reloads the counter and clears control bit 0, so the timer stops.
- R7: Writing control bit 4 as 1 loads the counter from the latch in the same cycle, and the first step follows on the next enabled cycle. Bit 4 always reads back 0. All other control bits read back as written.
- R8: With bit 6 of timer B's control set, timer B steps once per timer A underflow and ignores tick_i. Its underflow then lands on the same cycle as timer A's underflow that empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 2 | Underflow pulses, bit 0 timer A, bit 1 timer B |

## Verification
The free-running timer is swept over small reload values from 0 to 6 plus one multi-byte value. For each, the bench counts pulses and records the tick index of the first pulse, which separates an off-by-one period from a missing reload or a stretched pulse. The cascade is swept over every pair of A and B reload values from 0 to 3, where the product period and the alignment of B's pulse with A's pulses expose chaining slips. Directed sequences cover writes to a running timer, the force strobe, one-shot stop, control readback, and a chained B held still while A is stopped.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int NUM_TIMERS  = 2;
  // control byte field positions, decoded by timer_unit
  localparam int CTL_RUN     = 0;
  localparam int CTL_ONESHOT = 3;
  localparam int CTL_LOAD    = 4;
  localparam int CTL_CHAIN   = 6;
endpackage

// File: rtl/timer_unit.sv
module timer_unit
  import dual_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter bit CHAIN_EN = 1'b0,
  localparam int NB      = CNT_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              chain_tick_i,
  input  logic [NB-1:0]     lat_we_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              uflow_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, lat_q, lat_d;
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic step_src, step, uflow, force_ld, hi_ld;

  if (CHAIN_EN) begin : g_chain
    assign step_src = ctl_q[CTL_CHAIN] ? chain_tick_i : tick_i;
  end else begin : g_free
    logic unused_chain;
    assign unused_chain = chain_tick_i;
    assign step_src     = tick_i;
  end

  assign step     = ctl_q[CTL_RUN] & step_src;
  assign uflow    = step & (cnt_q == '0);
  assign force_ld = ctl_we_i & wdata_i[CTL_LOAD];
  assign hi_ld    = lat_we_i[NB-1] & ~ctl_q[CTL_RUN];

  always_comb begin
    lat_d = lat_q;
    for (int b = 0; b < NB; b++)
      if (lat_we_i[b]) lat_d[b*DATA_W +: DATA_W] = wdata_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (force_ld)   cnt_d = lat_q;
    else if (hi_ld) cnt_d = lat_d;
    else if (uflow) cnt_d = lat_q;
    else if (step)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    ctl_d = ctl_q;
    if (uflow && ctl_q[CTL_ONESHOT]) ctl_d[CTL_RUN] = 1'b0;
    if (ctl_we_i) begin
      ctl_d           = wdata_i;
      ctl_d[CTL_LOAD] = 1'b0;  // strobe only
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
      ctl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
      ctl_q <= ctl_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign ctl_o   = ctl_q;
  assign uflow_o = uflow;

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> cnt_q == $past(lat_q))
    else $error("R5 reload mismatch");

  assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uflow_o && ctl_q[CTL_ONESHOT] && !ctl_we_i) |=> !ctl_q[CTL_RUN])
    else $error("R6 one-shot did not stop");

  assert_force_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[CTL_LOAD]) |=> cnt_q == $past(lat_q))
    else $error("R7 force load missed");

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q != '0 && !force_ld) |=> cnt_q == $past(cnt_q) - CNT_W'(1))
    else $error("R4 step wrong");

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !force_ld && !hi_ld) |=> $stable(cnt_q))
    else $error("R4 counter moved while idle");

  assert_hi_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_ld && !force_ld) |=> cnt_q == lat_q)
    else $error("R3 high-byte load missed");
endmodule

// File: rtl/timer_rdmux.sv
module timer_rdmux
  import dual_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  localparam int NB     = CNT_W / DATA_W,
  localparam int ADDR_W = $clog2(NUM_TIMERS * NB + NUM_TIMERS)
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0] ctl_i,
  output logic [DATA_W-1:0]                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      for (int b = 0; b < NB; b++)
        if (addr_i == ADDR_W'(t * NB + b)) rdata_o = cnt_i[t][b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(NUM_TIMERS * NB + t)) rdata_o = ctl_i[t];
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dual_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8,
  localparam int NB     = CNT_W / DATA_W,
  localparam int ADDR_W = $clog2(NUM_TIMERS * NB + NUM_TIMERS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_TIMERS-1:0] irq_o
);
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] ctl;
  logic [NUM_TIMERS-1:0]             uflow, chain_src;

  // timer t steps on underflows of timer t-1 in chain mode
  assign chain_src = {uflow[NUM_TIMERS-2:0], 1'b0};

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [NB-1:0] lat_we;
    logic          ctl_we;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign lat_we[b] = we_i && (addr_i == ADDR_W'(t * NB + b));
    end
    assign ctl_we = we_i && (addr_i == ADDR_W'(NUM_TIMERS * NB + t));

    timer_unit #(
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .CHAIN_EN (t != 0)
    ) u_unit (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .chain_tick_i (chain_src[t]),
      .lat_we_i     (lat_we),
      .ctl_we_i     (ctl_we),
      .wdata_i      (wdata_i),
      .cnt_o        (cnt[t]),
      .ctl_o        (ctl[t]),
      .uflow_o      (uflow[t])
    );
  end

  timer_rdmux #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .ctl_i   (ctl),
    .rdata_o (rdata_o)
  );

  assign irq_o = uflow;

  assert_chain_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[1][CTL_CHAIN] && ctl[1][CTL_RUN] && !uflow[0] && !we_i) |=> $stable(cnt[1]))
    else $error("R8 chained timer moved without upstream underflow");

  assert_chain_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[1][CTL_CHAIN] && uflow[1]) |-> uflow[0])
    else $error("R8 chained underflow without upstream underflow");
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1'b1; addr = a[2:0]; wdata = d[7:0];
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = a[2:0]; #1 v = rdata;
  endtask

  task automatic rd16(int t, output int v);
    int lo, hi;
    rd(2*t, lo); rd(2*t+1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic set_latch(int t, int v);
    wr(2*t, v & 8'hFF); wr(2*t+1, (v >> 8) & 8'hFF);
  endtask

  task automatic run(int n, output int na, output int nb, output int fa, output int fb);
    na = 0; nb = 0; fa = -1; fb = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; #1;
      if (irq[0]) begin if (na == 0) fa = i; na++; end
      if (irq[1]) begin if (nb == 0) fb = i; nb++; end
    end
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, na, nb, fa, fb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin rd(a, v); check("R1 reset read", v, 0); end
    check("R1 irq idle", int'(irq), 0);

    // R3: high byte write loads stopped counter
    set_latch(0, 16'h1234); rd16(0, v); check("R3 load A", v, 16'h1234);
    set_latch(1, 16'hABCD); rd16(1, v); check("R3 load B", v, 16'hABCD);

    // R4: counting, gaps and stop
    wr(4, 8'h01);
    run(2, na, nb, fa, fb); rd16(0, v); check("R4 two steps", v, 16'h1232);
    repeat (5) @(negedge clk);
    rd16(0, v); check("R4 hold without tick", v, 16'h1232);
    // R2: latch writes do not disturb a running counter
    set_latch(0, 16'h5000); rd16(0, v); check("R2 running unaffected", v, 16'h1232);
    // R7: force load, strobe reads 0, first step next tick
    wr(4, 8'h11); rd16(0, v); check("R7 force load", v, 16'h5000);
    rd(4, v); check("R7 strobe reads zero", v, 8'h01);
    run(1, na, nb, fa, fb); rd16(0, v); check("R7 step after load", v, 16'h4FFF);
    wr(4, 8'h00);
    run(3, na, nb, fa, fb); rd16(0, v); check("R4 hold when stopped", v, 16'h4FFF);

    // R5: period sweep on timer A
    for (int n = 0; n <= 7; n++) begin
      int lv;
      lv = (n == 7) ? 256 : n;
      set_latch(0, lv); wr(4, 8'h11);
      run(3 * (lv + 1), na, nb, fa, fb);
      check("R5 A pulse count", na, 3);
      check("R5 A first pulse", fa, lv);
      check("R5 B quiet", nb, 0);
      rd16(0, v); check("R5 A reloaded", v, lv);
      wr(4, 8'h00);
    end
    // R5: timer B free running
    set_latch(1, 4); wr(5, 8'h11);
    run(10, na, nb, fa, fb);
    check("R5 B pulse count", nb, 2);
    check("R5 B first pulse", fb, 4);
    wr(5, 8'h00);

    // R6: one-shot
    set_latch(0, 3); wr(4, 8'h19);
    run(12, na, nb, fa, fb);
    check("R6 single pulse", na, 1);
    rd16(0, v); check("R6 reloaded", v, 3);
    rd(4, v); check("R6 run cleared", v, 8'h08);
    wr(4, 8'h00);

    // R8: cascade sweep
    for (int a = 0; a <= 3; a++) begin
      for (int b = 0; b <= 3; b++) begin
        set_latch(0, a); set_latch(1, b);
        wr(5, 8'h51); wr(4, 8'h11);
        run(2 * (a + 1) * (b + 1), na, nb, fa, fb);
        check("R8 B pulses", nb, 2);
        check("R8 B first pulse", fb, (a + 1) * (b + 1) - 1);
        check("R8 A pulses", na, 2 * (b + 1));
        rd16(1, v); check("R8 B reloaded", v, b);
        wr(4, 8'h00); wr(5, 8'h00);
      end
    end
    // R8: chained B ignores tick while A stopped
    set_latch(1, 2); wr(5, 8'h51);
    run(5, na, nb, fa, fb);
    check("R8 no B pulse", nb, 0);
    rd16(1, v); check("R8 B held", v, 2);
    wr(5, 8'h00);

    // R7: control readback
    wr(5, 8'hA4); rd(5, v); check("R7 B control readback", v, 8'hA4);
    set_latch(0, 16'h0777); wr(4, 8'h96);
    rd(4, v); check("R7 A control strobe masked", v, 8'h86);
    rd16(0, v); check("R7 A forced while stopped", v, 16'h0777);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule